// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Level and Idle Timeout

This block holds the bytes a serial receiver has assembled until host logic reads them. It is a sixteen-slot first-in first-out store of bytes whose read and write positions wrap around. Beside the data it keeps a set of occupancy flags (empty, full, overflow) that feed an interrupt unit. The host can read the queue as soon as anything is present, or wait for one of two events. The first is a trigger flag, raised once the number of stored bytes reaches a programmable level. The second is an idle-timeout flag, raised when no byte has arrived for four character times.

The receiver presents each byte with a one-cycle write strobe. The host pulls one byte per read strobe and finds it on the read-data output in the following cycle. A receiver-reset strobe empties the queue and clears its status without touching the trigger level. The trigger level is a register, loaded through its own strobe, that comes up at 32, so the trigger stays quiet until software lowers it. The character time is a cycle count supplied from outside. Bit-level reception and error detection are done elsewhere.

Top module: `rx_byte_queue`

## Requirements
- R1: Accepted bytes come out in the order they were written, across wrap-around of both positions; a read of a non-empty queue shows the oldest byte on `rdData` one cycle after the read strobe.
- R2: A write strobe with no read strobe, while 16 bytes are held, drops the byte, leaves the contents unchanged and sets `overflowFlag`.
- R3: `fullFlag` is 1 exactly when 16 bytes are held.
- R4: After an accepted write that leaves the count at or above the trigger level, `trigFlag` is 1. After a read that leaves the count below the trigger level, `trigFlag` is 0. No other event changes it.
- R5: Any read strobe clears `fullFlag` (unless a write in the same cycle keeps 16 held) and clears `overflowFlag`.
- R6: A read of an empty queue puts 0x00 on `rdData` and sets `emptyFlag`. A read that brings the count to zero also sets `emptyFlag`.
- R7: Every accepted write clears `emptyFlag` and restarts an idle timer of 4 × `charTime` cycles. `timeoutFlag` rises on the clock edge 4 × `charTime` cycles after the last accepted write (for `charTime` ≥ 1) and stays set until a receiver reset.
- R8: `rxReset` (or the system reset `rstN` low) sets the count and both positions to zero, sets `emptyFlag` and clears `fullFlag`, `overflowFlag` and `timeoutFlag`. `rxReset` leaves `trigFlag` and the trigger level unchanged and takes priority over reads and writes in the same cycle.
- R9: The trigger level is 32 after system reset. A `trigWr` strobe loads it from `trigVal`.
- R10: A read and a write in the same cycle on a non-empty queue (full included) accept the write, return the oldest byte and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous system reset |
| wrValid | input | 1 | Byte-arrival strobe from the receiver |
| wrData | input | 8 | Received byte |
| rdStrobe | input | 1 | Host read strobe, one byte per cycle |
| rxReset | input | 1 | Receiver reset strobe: empties the queue |
| trigWr | input | 1 | Load strobe for the trigger level |
| trigVal | input | 6 | New trigger level (0 to 63) |
| charTime | input | 16 | One character time in clock cycles |
| rdData | output | 8 | Byte returned by the last read (0x00 if the queue was empty) |
| emptyFlag | output | 1 | Queue empty |
| fullFlag | output | 1 | Queue holds 16 bytes |
| overflowFlag | output | 1 | A byte was dropped on a full queue |
| trigFlag | output | 1 | Count reached the trigger level |
| timeoutFlag | output | 1 | No byte arrived for four character times |

## Verification
The assertions assume that every input is a clean, synchronous level sampled on the rising edge, and that strobes may arrive back to back. The timer assertion also assumes `charTime` is nonzero whenever a write reloads the timer. The bench drives every input on the falling edge and holds `charTime` at 3 for the whole run, so the idle window is a fixed twelve cycles. Reads and writes are issued only as whole-cycle pulses, and they overlap only where a same-cycle read and write is the case under test.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Strobes the control issues to the byte store each cycle.
  typedef struct packed {
    logic push;      // store wrData at the write position
    logic pop;       // present oldest byte and advance read position
    logic popEmpty;  // read of an empty queue: present zero
    logic flush;     // return both positions to zero
  } qStrobe_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  qStrobe_t      strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPos(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPos(wrPtr);
      if (strb.pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= nextPos(rdPtr);
      end else if (strb.popEmpty) begin
        rdData <= '0;
      end
    end
  end

  // R6: an empty read presents zero on the next cycle
  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.popEmpty |=> (rdData == '0));

  // R8: a flush never comes with data movement
  a_r8_flush_alone: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |-> !(strb.push || strb.pop || strb.popEmpty));

  // R6: a read is either a real pop or an empty read, never both
  a_r6_read_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pop && strb.popEmpty));
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int CTW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           load,
  input  logic           clear,
  input  logic [CTW-1:0] charTime,
  output logic           expire
);
  localparam int TW = CTW + 2;

  logic [TW-1:0] remain;
  logic          armed;

  assign expire = armed && (remain <= TW'(1));

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (load) begin
      armed  <= 1'b1;
      remain <= {charTime, 2'b00};
    end else if (armed) begin
      if (expire) armed <= 1'b0;
      else        remain <= remain - 1'b1;
    end
  end

  // R7: a reload with a nonzero character time cannot expire right after
  a_r7_reload_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (load && !clear && charTime != '0) |=> !expire);

  // R7: an expiry disarms the timer unless it is reloaded
  a_r7_single_shot: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !load) |=> !expire);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int LW        = 6,
  parameter int TRIG_INIT = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          rdStrobe,
  input  logic          rxReset,
  input  logic          trigWr,
  input  logic [LW-1:0] trigVal,
  input  logic          expire,
  output qStrobe_t      strb,
  output logic          timerLoad,
  output logic          emptyFlag,
  output logic          fullFlag,
  output logic          overflowFlag,
  output logic          trigFlag,
  output logic          timeoutFlag
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int KW = (CW > LW) ? CW : LW;

  logic [CW-1:0] count, nextCount;
  logic [LW-1:0] trigLevel;
  logic          doPush, doPop, doPopEmpty;
  logic          atTrig;

  assign doPop      = rdStrobe && !rxReset && (count != '0);
  assign doPopEmpty = rdStrobe && !rxReset && (count == '0);
  assign doPush     = wrValid && !rxReset && ((count < CW'(DEPTH)) || doPop);
  assign nextCount  = count + CW'(doPush) - CW'(doPop);
  assign atTrig     = KW'(nextCount) >= KW'(trigLevel);

  always_comb begin
    strb.push     = doPush;
    strb.pop      = doPop;
    strb.popEmpty = doPopEmpty;
    strb.flush    = rxReset;
  end
  assign timerLoad = doPush;

  always_ff @(posedge clk) begin
    if (!rstN)       trigLevel <= LW'(TRIG_INIT);
    else if (trigWr) trigLevel <= trigVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count        <= '0;
      emptyFlag    <= 1'b1;
      fullFlag     <= 1'b0;
      overflowFlag <= 1'b0;
      trigFlag     <= 1'b0;
      timeoutFlag  <= 1'b0;
    end else if (rxReset) begin
      count        <= '0;
      emptyFlag    <= 1'b1;
      fullFlag     <= 1'b0;
      overflowFlag <= 1'b0;
      timeoutFlag  <= 1'b0;
    end else begin
      count    <= nextCount;
      fullFlag <= (nextCount == CW'(DEPTH));
      if (rdStrobe)                overflowFlag <= 1'b0;
      else if (wrValid && !doPush) overflowFlag <= 1'b1;
      if (doPush)                                emptyFlag <= 1'b0;
      else if (rdStrobe && nextCount == '0)      emptyFlag <= 1'b1;
      if (doPush && atTrig)                      trigFlag  <= 1'b1;
      else if (rdStrobe && !atTrig)              trigFlag  <= 1'b0;
      if (expire) timeoutFlag <= 1'b1;
    end
  end

  // R2: write to a full queue without a read drops the byte
  a_r2_drop_on_full: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !rdStrobe && !rxReset && count == CW'(DEPTH))
      |=> (overflowFlag && count == CW'(DEPTH)));

  // R3: full and empty never hold together
  a_r3_full_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> !emptyFlag);

  // R5: a read clears the overflow flag
  a_r5_read_clears_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !rxReset) |=> !overflowFlag);

  // R8: receiver reset state
  a_r8_rx_reset: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |=> (emptyFlag && !fullFlag && !overflowFlag && !timeoutFlag && count == '0));

  // R10: read and write together keep the count
  a_r10_count_kept: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && doPop) |=> $stable(count));

  // R7: timer expiry raises the timeout flag
  a_r7_timeout_set: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !rxReset) |=> timeoutFlag);
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int LW        = 6,
  parameter int CTW       = 16,
  parameter int TRIG_INIT = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrValid,
  input  logic [DW-1:0]  wrData,
  input  logic           rdStrobe,
  input  logic           rxReset,
  input  logic           trigWr,
  input  logic [LW-1:0]  trigVal,
  input  logic [CTW-1:0] charTime,
  output logic [DW-1:0]  rdData,
  output logic           emptyFlag,
  output logic           fullFlag,
  output logic           overflowFlag,
  output logic           trigFlag,
  output logic           timeoutFlag
);
  qStrobe_t strb;
  logic     timerLoad, expire;

  rxq_ctrl #(.DEPTH(DEPTH), .LW(LW), .TRIG_INIT(TRIG_INIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
    .rxReset(rxReset), .trigWr(trigWr), .trigVal(trigVal), .expire(expire),
    .strb(strb), .timerLoad(timerLoad), .emptyFlag(emptyFlag),
    .fullFlag(fullFlag), .overflowFlag(overflowFlag), .trigFlag(trigFlag),
    .timeoutFlag(timeoutFlag)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) i_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData)
  );

  rxq_idle_timer #(.CTW(CTW)) i_timer (
    .clk(clk), .rstN(rstN), .load(timerLoad), .clear(rxReset),
    .charTime(charTime), .expire(expire)
  );
endmodule

// File: tb/test_rx_byte_queue.sv
`timescale 1ns/1ps
module test_rx_byte_queue;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0, rdStrobe = 1'b0, rxReset = 1'b0, trigWr = 1'b0;
  logic [7:0] wrData = '0;
  logic [5:0] trigVal = '0;
  logic [15:0] charTime = 16'd3;
  logic [7:0] rdData;
  logic emptyFlag, fullFlag, overflowFlag, trigFlag, timeoutFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_byte_queue i_rx_byte_queue (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .rdStrobe(rdStrobe), .rxReset(rxReset), .trigWr(trigWr),
    .trigVal(trigVal), .charTime(charTime), .rdData(rdData),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .overflowFlag(overflowFlag),
    .trigFlag(trigFlag), .timeoutFlag(timeoutFlag)
  );

  // {wr, rd, data[7:0], expRd[7:0], empty, full, ovf, trig}; trigger level 4
  localparam logic [21:0] VEC [10] = '{
    {1'b1, 1'b0, 8'h11, 8'h00, 4'b0000},  // R1 R7 write clears empty
    {1'b1, 1'b0, 8'h22, 8'h00, 4'b0000},
    {1'b1, 1'b0, 8'h33, 8'h00, 4'b0000},
    {1'b1, 1'b0, 8'h44, 8'h00, 4'b0001},  // R4 count 4 reaches level
    {1'b0, 1'b1, 8'h00, 8'h11, 4'b0000},  // R4 count 3 clears trigger
    {1'b1, 1'b1, 8'h55, 8'h22, 4'b0000},  // R10 read+write, count stays 3
    {1'b0, 1'b1, 8'h00, 8'h33, 4'b0000},
    {1'b0, 1'b1, 8'h00, 8'h44, 4'b0000},
    {1'b0, 1'b1, 8'h00, 8'h55, 4'b1000},  // R6 last byte out sets empty
    {1'b0, 1'b1, 8'h00, 8'h00, 4'b1000}   // R6 empty read gives zero
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] d, input logic rd);
    @(negedge clk);
    wrValid = wr; wrData = d; rdStrobe = rd;
    @(posedge clk); #1;
    wrValid = 1'b0; rdStrobe = 1'b0;
  endtask

  task automatic pulseRxReset();
    @(negedge clk); rxReset = 1'b1;
    @(posedge clk); #1; rxReset = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic flags(input string tag, input logic [3:0] exp);
    chk(tag, {emptyFlag, fullFlag, overflowFlag, trigFlag}, exp);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R8 reset state
    flags("R8 reset flags", 4'b1000);
    chk("R8 reset timeout", timeoutFlag, 0);
    chk("R8 reset rdData", rdData, 8'h00);

    // fill 16 with default trigger level 32
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 8'hA0 + 8'(i), 1'b0);
      if (i == 14) chk("R3 not full at 15", fullFlag, 0);
    end
    chk("R3 full at 16", fullFlag, 1);
    chk("R9 trigger level 32 stays quiet", trigFlag, 0);
    step(1'b1, 8'hEE, 1'b0);
    flags("R2 overflow on full", 4'b0110);
    step(1'b0, 8'h00, 1'b1);
    chk("R2 dropped byte not at head", rdData, 8'hA0);
    flags("R5 read clears full and overflow", 4'b0000);

    pulseRxReset();
    flags("R8 rx reset flags", 4'b1000);
    chk("R8 rx reset timeout", timeoutFlag, 0);
    step(1'b0, 8'h00, 1'b1);
    chk("R6 R8 empty after reset reads zero", rdData, 8'h00);
    chk("R6 empty flag", emptyFlag, 1);

    @(negedge clk); trigWr = 1'b1; trigVal = 6'd4;
    @(posedge clk); #1; trigWr = 1'b0;

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][21], VEC[i][19:12], VEC[i][20]);
      chk($sformatf("R1 R4 R10 vec%0d rdData", i), rdData, VEC[i][11:4]);
      flags($sformatf("R4 R6 vec%0d flags", i), VEC[i][3:0]);
    end

    // wrap-around, full read+write
    for (int i = 0; i < 16; i++) step(1'b1, 8'hB0 + 8'(i), 1'b0);
    step(1'b1, 8'hC0, 1'b1);
    chk("R10 read at full returns head", rdData, 8'hB0);
    chk("R10 R3 still full", fullFlag, 1);
    for (int i = 1; i < 17; i++) begin
      step(1'b0, 8'h00, 1'b1);
      chk("R1 wrap order", rdData, (i == 16) ? 8'hC0 : 8'hB0 + 8'(i));
    end
    chk("R6 empty after drain", emptyFlag, 1);

    // idle timeout: charTime 3 -> 12 cycles
    pulseRxReset();
    step(1'b1, 8'h5A, 1'b0);
    idle(6);
    step(1'b1, 8'h5B, 1'b0);   // R7 restart
    idle(10);
    chk("R7 restarted timer quiet", timeoutFlag, 0);
    idle(1);
    chk("R7 no timeout at 11", timeoutFlag, 0);
    idle(1);
    chk("R7 timeout at 12", timeoutFlag, 1);
    idle(20);
    chk("R7 timeout sticky", timeoutFlag, 1);
    pulseRxReset();
    chk("R8 rx reset clears timeout", timeoutFlag, 0);
    chk("R8 rx reset keeps trigger", trigFlag, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule